// File: doc/BRIEF.md
# Entropy Word Buffer with Register Front End

This block sits between a raw entropy source and a processor bus. A serial stream of entropy bits enters on a valid/bit pair. Each group of 32 bits is packed, most significant bit first, into a word. Words are collected in a small buffer. Once the buffer holds a full burst of four words, a ready flag tells software that it may read all four words from the data register back to back, without polling again between reads.

Two health monitors watch the bit stream. The first catches a long run of identical bits. The second catches a word that equals the word before it. Either condition raises a live error bit and latches a sticky error bit. Both conditions block buffering. To recover, software clears the sticky bit and then performs a fixed number of dummy data reads, after which filling restarts from an empty buffer. A separate sticky flag records pulses on a clock-check input, and a control bit can mask that input. The bus is a single-cycle valid/write/address port, and read data is returned one cycle later.

Top module: `rng_regif`

## Requirements
- R1: After reset the control word, the status word and the read data are all zero, and the data register reads 0.
- R2: Registers sit at byte offset 0x0 (control), 0x4 (status) and 0x8 (data). Control keeps only bit 2 (generator on) and bit 5 (clock-check masked) and reads them back. Read data appears on `bus_rdata` one cycle after the read strobe.
- R3: While bit 2 of control is set, each accepted entropy bit is shifted in, most significant bit first, and every 32 bits form one word. While bit 2 is clear, entropy bits are ignored.
- R4: Status bit 0 (ready) rises once four words are buffered. The following four data reads return those words, oldest first.
- R5: Ready falls on the fourth data read. A data read while ready is low returns 0 and removes nothing.
- R6: Words that arrive while ready is high are discarded. Refilling after a burst needs four fresh words.
- R7: A run of 64 identical consecutive entropy bits is a seed error. A run of 63 is not.
- R8: A completed word equal to the previous word is a seed error. Status bit 2 shows the live condition, and it clears when the next completed word differs.
- R9: While a seed error is live, sticky status bit 6 is set. A status write clears sticky bit 5 and sticky bit 6 wherever the written bit is 0.
- R10: While the live error, the sticky seed flag or a pending drain is present, no word is buffered, the buffer is emptied and ready stays low.
- R11: After the live error ends and sticky bit 6 is cleared, exactly 12 data reads must occur before buffering resumes from an empty buffer.
- R12: A pulse on `clk_check_fail` sets sticky status bit 5 when control bit 5 is 0. The pulse is ignored when control bit 5 is 1.
- R13: Writing 0 to the control register stops packing and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, one cycle after the strobe |
| ent_valid | input | 1 | Entropy bit qualifier |
| ent_bit | input | 1 | Entropy bit |
| clk_check_fail | input | 1 | Clock-check failure pulse |

## Verification
A bit given at one edge completes a word at that edge. The word enters the buffer one edge later, and ready rises the edge after that. The bench therefore lets at least three idle cycles pass after the last bit before it reads status. Live and sticky error bits are registered at the edge of the offending bit or word, or one edge later, so they too are settled before the next status read. Every register read is sampled on the falling edge that follows the strobe's rising edge, which is where the one-cycle read latency places the data.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_STAT  = 4;
  localparam int unsigned OFS_DATA  = 8;
  localparam int unsigned CTL_EN    = 2;
  localparam int unsigned CTL_CKOFF = 5;
  localparam int unsigned ST_RDY    = 0;
  localparam int unsigned ST_SLIVE  = 2;
  localparam int unsigned ST_CKERR  = 5;
  localparam int unsigned ST_SERR   = 6;
endpackage

// File: rtl/rng_bit_packer.sv
// Serial-to-word packer with run-length and word-repeat health monitors.
module rng_bit_packer #(
  parameter int WORD_W    = 32,
  parameter int RUN_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              seed_live
);
  localparam int BW = $clog2(WORD_W);
  localparam int RW = $clog2(RUN_LIMIT + 1);

  logic [WORD_W-1:0] sh, prev_word, nxt;
  logic [BW-1:0]     bcnt;
  logic [RW-1:0]     run_len;
  logic              last_bit, have_last, have_prev, word_rep;

  assign nxt       = {sh[WORD_W-2:0], bit_in};
  assign seed_live = (run_len >= RW'(RUN_LIMIT)) | word_rep;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh        <= '0;
      prev_word <= '0;
      word      <= '0;
      bcnt      <= '0;
      run_len   <= '0;
      last_bit  <= 1'b0;
      have_last <= 1'b0;
      have_prev <= 1'b0;
      word_rep  <= 1'b0;
      word_vld  <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (bit_vld) begin
        sh        <= nxt;
        last_bit  <= bit_in;
        have_last <= 1'b1;
        if (have_last && bit_in == last_bit) begin
          if (run_len < RW'(RUN_LIMIT)) run_len <= run_len + 1'b1;
        end else begin
          run_len <= RW'(1);
        end
        if (bcnt == BW'(WORD_W - 1)) begin
          bcnt      <= '0;
          word_vld  <= 1'b1;
          word      <= nxt;
          prev_word <= nxt;
          have_prev <= 1'b1;
          word_rep  <= have_prev && (nxt == prev_word);
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rng_word_fifo.sv
// Burst buffer: fills only while not ready, drains only while ready.
module rng_word_fifo #(
  parameter int WORD_W    = 32,
  parameter int BUF_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WORD_W-1:0]            push_data,
  input  logic                         pop_req,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         ready,
  output logic [$clog2(BUF_DEPTH+1)-1:0] level
);
  localparam int PW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int LW = $clog2(BUF_DEPTH + 1);

  logic [WORD_W-1:0] mem [BUF_DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign push_ok = push && !flush && !ready && (level < LW'(BUF_DEPTH));
  assign pop_ok  = pop_req && ready && !flush;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (pop_req) begin
      rd_data <= ready ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ready  <= 1'b0;
    end else begin
      if (push_ok) begin
        wr_ptr <= (wr_ptr == PW'(BUF_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        level  <= level + 1'b1;
      end
      if (pop_ok) begin
        rd_ptr <= (rd_ptr == PW'(BUF_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        level  <= level - 1'b1;
      end
      if (!ready && level == LW'(BUF_DEPTH)) ready <= 1'b1;
      else if (pop_ok && level == LW'(1))    ready <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_regif.sv
module rng_regif
  import rng_regif_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BUF_DEPTH   = 4,
  parameter int RUN_LIMIT   = 64,
  parameter int DRAIN_WORDS = 12,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic              ent_bit,
  input  logic              clk_check_fail
);
  localparam int DW = $clog2(DRAIN_WORDS + 1);
  localparam int LW = $clog2(BUF_DEPTH + 1);

  logic              gen_en, ckoff, clk_err, seed_err, seed_live, blocked;
  logic              word_vld, buf_ready, sel_data_q;
  logic [WORD_W-1:0] word, fifo_rdata, reg_rdata_q, ctrl_word, stat_word;
  logic [LW-1:0]     buf_level;
  logic [DW-1:0]     drain_cnt;
  logic              hit_ctrl, hit_stat, hit_data, rd, wr;

  assign rd       = bus_valid && !bus_write;
  assign wr       = bus_valid && bus_write;
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign blocked  = seed_live || seed_err || (drain_cnt != '0);

  rng_bit_packer #(.WORD_W(WORD_W), .RUN_LIMIT(RUN_LIMIT)) u_pack (
    .clk(clk), .rst(rst), .clr(!gen_en), .bit_vld(ent_valid), .bit_in(ent_bit),
    .word_vld(word_vld), .word(word), .seed_live(seed_live)
  );

  rng_word_fifo #(.WORD_W(WORD_W), .BUF_DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst(rst), .flush(!gen_en || blocked),
    .push(word_vld && !blocked), .push_data(word),
    .pop_req(rd && hit_data), .rd_data(fifo_rdata),
    .ready(buf_ready), .level(buf_level)
  );

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CTL_EN]    = gen_en;
    ctrl_word[CTL_CKOFF] = ckoff;
    stat_word            = '0;
    stat_word[ST_RDY]    = buf_ready;
    stat_word[ST_SLIVE]  = seed_live;
    stat_word[ST_CKERR]  = clk_err;
    stat_word[ST_SERR]   = seed_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en      <= 1'b0;
      ckoff       <= 1'b0;
      clk_err     <= 1'b0;
      seed_err    <= 1'b0;
      drain_cnt   <= '0;
      sel_data_q  <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      if (wr && hit_ctrl) begin
        gen_en <= bus_wdata[CTL_EN];
        ckoff  <= bus_wdata[CTL_CKOFF];
      end
      if (wr && hit_stat) begin
        if (!bus_wdata[ST_CKERR]) clk_err  <= 1'b0;
        if (!bus_wdata[ST_SERR])  seed_err <= 1'b0;
      end
      if (clk_check_fail && !ckoff) clk_err  <= 1'b1;
      if (seed_live)                seed_err <= 1'b1;
      if (seed_live)
        drain_cnt <= DW'(DRAIN_WORDS);
      else if (rd && hit_data && drain_cnt != '0)
        drain_cnt <= drain_cnt - 1'b1;
      if (rd) begin
        sel_data_q  <= hit_data;
        reg_rdata_q <= hit_ctrl ? ctrl_word : (hit_stat ? stat_word : '0);
      end
    end
  end

  assign bus_rdata = sel_data_q ? fifo_rdata : reg_rdata_q;
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk
  import rng_regif_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_DEPTH = 4,
  parameter int ADDR_W    = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           bus_valid,
  input logic                           bus_write,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [WORD_W-1:0]              bus_rdata,
  input logic                           clk_check_fail,
  input logic                           gen_en,
  input logic                           ckoff,
  input logic                           seed_live,
  input logic                           seed_err,
  input logic                           clk_err,
  input logic                           blocked,
  input logic                           buf_ready,
  input logic [$clog2(BUF_DEPTH+1)-1:0] buf_level
);
  localparam int LW = $clog2(BUF_DEPTH + 1);

  p_ready_full_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_ready) |-> buf_level == LW'(BUF_DEPTH));

  p_ready_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
    buf_ready |-> buf_level != '0);

  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_DATA) && !buf_ready)
      |=> bus_rdata == '0);

  p_sticky_seed_r9: assert property (@(posedge clk) disable iff (rst)
    seed_live |=> seed_err);

  p_blocked_empty_r10: assert property (@(posedge clk) disable iff (rst)
    blocked |=> (buf_level == '0 && !buf_ready));

  p_clk_err_set_r12: assert property (@(posedge clk) disable iff (rst)
    (clk_check_fail && !ckoff) |=> clk_err);

  p_off_empty_r13: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> buf_level == '0);
endmodule

bind rng_regif rng_regif_chk #(
  .WORD_W(WORD_W), .BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .clk_check_fail(clk_check_fail),
  .gen_en(gen_en), .ckoff(ckoff), .seed_live(seed_live), .seed_err(seed_err),
  .clk_err(clk_err), .blocked(blocked), .buf_ready(buf_ready), .buf_level(buf_level)
);

// File: tb/tb_rng_regif.sv
`timescale 1ns/1ps
module tb_rng_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_valid = 1'b0, ent_bit = 1'b0, clk_check_fail = 1'b0;

  int checks = 0, fails = 0, wn = 1;
  bit done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8;

  always #10 clk = ~clk;

  rng_regif dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_bit(ent_bit), .clk_check_fail(clk_check_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic feed(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); ent_valid = 1; ent_bit = w[i];
    end
    @(negedge clk); ent_valid = 0;
    idle(3);
  endtask

  function automatic logic [31:0] fresh();
    fresh = {16'hA5C3, wn[15:0]};
    wn++;
  endfunction

  task automatic restart();
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CTRL, 32'h4);
  endtask

  task automatic recover();
    logic [31:0] d;
    bus_wr(A_STAT, 32'h0);
    for (int i = 0; i < 12; i++) bus_rd(A_DATA, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    bus_rd(A_STAT, d); chk("R1 status", d, 32'h0);
    bus_rd(A_DATA, d); chk("R1 data", d, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, d); chk("R2 ctrl keeps bits 2,5", d, 32'h24);
    bus_wr(A_CTRL, 32'h4);
    bus_rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h4);
  endtask

  task automatic t_disabled();
    logic [31:0] d, w[4];
    bus_wr(A_CTRL, 32'h0);
    for (int i = 0; i < 4; i++) feed(fresh());
    bus_wr(A_CTRL, 32'h4);
    bus_rd(A_STAT, d); chk("R3 bits ignored when off", d, 32'h0);
    for (int i = 0; i < 3; i++) begin w[i] = fresh(); feed(w[i]); end
    bus_rd(A_STAT, d); chk("R4 three words not ready", d, 32'h0);
    w[3] = fresh(); feed(w[3]);
    bus_rd(A_STAT, d); chk("R4 ready after four", d, 32'h1);
    for (int i = 0; i < 4; i++) begin
      bus_rd(A_DATA, d); chk("R3 R4 word order", d, w[i]);
    end
    bus_rd(A_STAT, d); chk("R5 ready drops after fourth", d, 32'h0);
    bus_rd(A_DATA, d); chk("R5 empty read zero", d, 32'h0);
  endtask

  task automatic t_discard();
    logic [31:0] d, w[4];
    for (int i = 0; i < 4; i++) begin w[i] = fresh(); feed(w[i]); end
    feed(fresh());
    for (int i = 0; i < 4; i++) begin
      bus_rd(A_DATA, d); chk("R6 burst unchanged by extra word", d, w[i]);
    end
    for (int i = 0; i < 3; i++) feed(fresh());
    bus_rd(A_STAT, d); chk("R6 extra word was discarded", d, 32'h0);
    restart();
  endtask

  task automatic t_run();
    logic [31:0] d;
    restart();
    feed(32'hFFFF_FFFE); feed(32'h0); feed(32'h2);
    bus_rd(A_STAT, d); chk("R7 run of 63 no error", d, 32'h0);
    feed(32'hFFFF_FFFE); feed(32'h0); feed(32'h1);
    bus_rd(A_STAT, d); chk("R7 run of 64 latched sticky", d, 32'h40);
    recover();
    bus_rd(A_STAT, d); chk("R9 sticky cleared", d, 32'h0);
  endtask

  task automatic t_repeat();
    logic [31:0] d, w1, w[4];
    restart();
    w1 = fresh();
    feed(w1); feed(w1);
    bus_rd(A_STAT, d); chk("R8 R9 repeat live and sticky", d, 32'h44);
    feed(fresh());
    bus_rd(A_STAT, d); chk("R8 live clears on new word", d, 32'h40);
    for (int i = 0; i < 4; i++) feed(fresh());
    bus_rd(A_STAT, d); chk("R10 no buffering while sticky", d, 32'h40);
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, d); chk("R9 status write clears", d, 32'h0);
    for (int i = 0; i < 11; i++) bus_rd(A_DATA, d);
    for (int i = 0; i < 4; i++) feed(fresh());
    bus_rd(A_STAT, d); chk("R11 eleven reads not enough", d, 32'h0);
    bus_rd(A_DATA, d); chk("R11 drain read zero", d, 32'h0);
    for (int i = 0; i < 4; i++) begin w[i] = fresh(); feed(w[i]); end
    bus_rd(A_STAT, d); chk("R11 ready after twelve reads", d, 32'h1);
    for (int i = 0; i < 4; i++) begin
      bus_rd(A_DATA, d); chk("R11 fresh fill from empty", d, w[i]);
    end
  endtask

  task automatic t_clkerr();
    logic [31:0] d;
    @(negedge clk); clk_check_fail = 1; @(negedge clk); clk_check_fail = 0;
    bus_rd(A_STAT, d); chk("R12 clock error sets", d, 32'h20);
    bus_wr(A_STAT, 32'h40);
    bus_rd(A_STAT, d); chk("R9 R12 status write clears bit5", d, 32'h0);
    bus_wr(A_CTRL, 32'h24);
    @(negedge clk); clk_check_fail = 1; @(negedge clk); clk_check_fail = 0;
    bus_rd(A_STAT, d); chk("R12 masked pulse ignored", d, 32'h0);
    bus_wr(A_CTRL, 32'h4);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) feed(fresh());
    bus_rd(A_STAT, d); chk("R13 filled before stop", d, 32'h1);
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CTRL, 32'h4);
    bus_rd(A_STAT, d); chk("R13 stop empties buffer", d, 32'h0);
    bus_rd(A_DATA, d); chk("R13 data zero after stop", d, 32'h0);
  endtask

  initial begin
    idle(4);
    rst = 0;
    t_reset();
    t_regmap();
    t_disabled();
    t_discard();
    t_run();
    t_repeat();
    t_clkerr();
    t_stop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule